// File: doc/BRIEF.md
# Multi-Phase Repeated-Sampling Time Digitizer

This block turns the arrival time of an input edge into a digital timestamp. The timestamp has two parts. A coarse part is taken from a free-running cycle counter. A fine part is taken from a small set of sampling clocks that are phase-shifted across one period. Each phase sampler reports whether it has already seen the edge, so one pass yields a short thermometer-like pattern. On its own, that pattern only resolves the period into NPH bins, where NPH is the number of phases.

To improve on that bin, the block opens a gate on a recirculating delay loop when it accepts a hit. The loop lets the same edge travel around again with a controlled extra delay, and every trip produces a fresh sample pattern. A two-stage encoder turns each pattern into a fine word. An accumulator adds N such words. The sum keeps log2(N) extra fraction bits, which makes the effective bin N times narrower.

After a result is produced, the block stays blind for a fixed dead time. Hits that come while it is busy or dead are discarded and counted. The delay elements and the phase clocks themselves sit outside the block. They reach it as a per-pass valid strobe and a pattern vector.

Top module: `tdc_multiphase_refine`

## Requirements
- R1: After reset, loop_en_o is 0, res_vld_o is 0 and ovf_cnt_o is 0.
- R2: A hit_i seen at a rising edge while the block is idle raises loop_en_o immediately after that edge.
- R3: loop_en_o falls immediately after the rising edge that takes the N-th pass_vld_i since the gate opened. N defaults to 8.
- R4: Each pass's fine word is the number of set bits in the NPH-bit pass_smp_i pattern (0 to NPH), whatever their positions, so bubbles do not disturb it.
- R5: res_vld_o is high for exactly one cycle, starting two rising edges after the edge that took the N-th pass. res_fine_o then equals the sum of the N fine words, a width of clog2(NPH+1)+log2(N) bits, with a maximum of NPH*N.
- R6: pass_vld_i has no effect while the gate is closed, whether the block is idle, waiting for its result or in dead time. Such passes never enter a sum.
- R7: A hit at any of the DEAD_CYC+1 rising edges after the edge that raises res_vld_o is dropped and does not open the gate. A hit at the next edge is accepted.
- R8: Every rising edge with hit_i high while the block is not idle adds one to ovf_cnt_o. The count saturates at 2^OVF_W-1.
- R9: res_coarse_o equals the number of rising edges since reset release that came before the edge that accepted the hit, modulo 2^COARSE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_i | input | 1 | Request to timestamp a new edge |
| pass_vld_i | input | 1 | One recirculation pass has been sampled |
| pass_smp_i | input | NPH | Per-phase samples of the current pass |
| loop_en_o | output | 1 | Gate enable for the recirculating loop |
| res_vld_o | output | 1 | Result strobe, one cycle |
| res_coarse_o | output | COARSE_W | Coarse cycle stamp of the accepted hit |
| res_fine_o | output | clog2(NPH+1)+log2(N) | Sum of the N fine words |
| ovf_cnt_o | output | OVF_W | Saturating count of dropped hits |

## Verification
A pass counter that is off by one would change when loop_en_o falls by a cycle. That same error would pull in one pass too many or too few, so res_fine_o would be wrong in the very next result. A stale accumulator or encoder stage would leave residue from a previous hit or from an ignored pass. That residue shows up directly in the following res_fine_o sum. Errors in the dead-time counter or the state register show up at the edge just before and just after the end of dead time, as a gate that opens or stays shut and as ovf_cnt_o moving by the wrong amount.

// File: rtl/tdc_mp_pkg.sv
package tdc_mp_pkg;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_RUN,
        GS_WAIT,
        GS_DEAD
    } gate_state_e;

endpackage

// File: rtl/tdc_phase_encoder.sv
module tdc_phase_encoder #(
    parameter int NPH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_vld_i,
    input  logic [NPH-1:0]                smp_i,
    output logic                          fine_vld_o,
    output logic [$clog2(NPH+1)-1:0]      fine_o
);
    localparam int FW = $clog2(NPH + 1);

    typedef struct packed {
        logic           s1_vld;
        logic [NPH-1:0] s1_pat;
        logic           s2_vld;
        logic [FW-1:0]  s2_fine;
    } enc_state_t;

    enc_state_t    st_d, st_q;
    logic [NPH-1:0] ones_vec;
    logic [FW-1:0]  ones_cnt;

    // each phase contributes one vote; a bubble only moves a vote, never loses it
    for (genvar g = 0; g < NPH; g++) begin : g_vote
        assign ones_vec[g] = st_q.s1_pat[g];
    end

    always_comb begin
        ones_cnt = '0;
        for (int k = 0; k < NPH; k++) begin
            ones_cnt = ones_cnt + FW'(ones_vec[k]);
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.s1_vld = smp_vld_i;
        if (smp_vld_i) begin
            st_d.s1_pat = smp_i;
        end
        st_d.s2_vld = st_q.s1_vld;
        if (st_q.s1_vld) begin
            st_d.s2_fine = ones_cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fine_vld_o = st_q.s2_vld;
    assign fine_o     = st_q.s2_fine;

endmodule

// File: rtl/tdc_pass_accum.sv
module tdc_pass_accum #(
    parameter int FW = 3,
    parameter int N  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fine_vld_i,
    input  logic [FW-1:0]                 fine_i,
    output logic                          res_vld_o,
    output logic [FW+$clog2(N)-1:0]       res_sum_o
);
    localparam int SW = FW + $clog2(N);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic [SW-1:0] acc;
        logic [CW-1:0] cnt;
        logic          vld;
        logic [SW-1:0] sum;
    } acc_state_t;

    acc_state_t    st_d, st_q;
    logic [SW-1:0] total;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        total    = st_q.acc + SW'(fine_i);
        if (fine_vld_i) begin
            if (st_q.cnt == CW'(N - 1)) begin
                st_d.vld = 1'b1;
                st_d.sum = total;
                st_d.acc = '0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = total;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_vld_o = st_q.vld;
    assign res_sum_o = st_q.sum;

endmodule

// File: rtl/tdc_gate_ctrl.sv
module tdc_gate_ctrl
    import tdc_mp_pkg::*;
#(
    parameter int N        = 8,
    parameter int DEAD_CYC = 6,
    parameter int OVF_W    = 8,
    parameter int COARSE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hit_i,
    input  logic                pass_vld_i,
    input  logic                res_vld_i,
    output logic                loop_en_o,
    output logic                pass_take_o,
    output logic [COARSE_W-1:0] stamp_o,
    output logic [OVF_W-1:0]    ovf_cnt_o
);
    localparam int PW = $clog2(N + 1);
    localparam int DW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        gate_state_e         st;
        logic [PW-1:0]       passes;
        logic [DW-1:0]       dead;
        logic [OVF_W-1:0]    ovf;
        logic [COARSE_W-1:0] tick;
        logic [COARSE_W-1:0] stamp;
    } gate_reg_t;

    gate_reg_t r_d, r_q;
    logic      drop_hit;

    always_comb begin
        r_d      = r_q;
        r_d.tick = r_q.tick + 1'b1;
        drop_hit = hit_i && (r_q.st != GS_IDLE);

        if (drop_hit && (r_q.ovf != {OVF_W{1'b1}})) begin
            r_d.ovf = r_q.ovf + 1'b1;
        end

        unique case (r_q.st)
            GS_IDLE: begin
                if (hit_i) begin
                    r_d.st     = GS_RUN;
                    r_d.passes = '0;
                    r_d.stamp  = r_q.tick;
                end
            end
            GS_RUN: begin
                if (pass_vld_i) begin
                    if (r_q.passes == PW'(N - 1)) begin
                        r_d.st = GS_WAIT;
                    end else begin
                        r_d.passes = r_q.passes + 1'b1;
                    end
                end
            end
            GS_WAIT: begin
                if (res_vld_i) begin
                    r_d.st   = GS_DEAD;
                    r_d.dead = DW'(DEAD_CYC - 1);
                end
            end
            GS_DEAD: begin
                if (r_q.dead == '0) begin
                    r_d.st = GS_IDLE;
                end else begin
                    r_d.dead = r_q.dead - 1'b1;
                end
            end
            default: r_d.st = GS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= GS_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign loop_en_o   = (r_q.st == GS_RUN);
    assign pass_take_o = (r_q.st == GS_RUN) && pass_vld_i;
    assign stamp_o     = r_q.stamp;
    assign ovf_cnt_o   = r_q.ovf;

endmodule

// File: rtl/tdc_multiphase_refine.sv
module tdc_multiphase_refine #(
    parameter int NPH      = 4,
    parameter int N        = 8,
    parameter int DEAD_CYC = 6,
    parameter int OVF_W    = 8,
    parameter int COARSE_W = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  hit_i,
    input  logic                                  pass_vld_i,
    input  logic [NPH-1:0]                        pass_smp_i,
    output logic                                  loop_en_o,
    output logic                                  res_vld_o,
    output logic [COARSE_W-1:0]                   res_coarse_o,
    output logic [$clog2(NPH+1)+$clog2(N)-1:0]    res_fine_o,
    output logic [OVF_W-1:0]                      ovf_cnt_o
);
    localparam int FW = $clog2(NPH + 1);
    localparam int SW = FW + $clog2(N);

    logic          pass_take;
    logic          fine_vld;
    logic [FW-1:0] fine_word;
    logic          sum_vld;
    logic [SW-1:0] sum_val;

    tdc_gate_ctrl #(
        .N        (N),
        .DEAD_CYC (DEAD_CYC),
        .OVF_W    (OVF_W),
        .COARSE_W (COARSE_W)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit_i),
        .pass_vld_i  (pass_vld_i),
        .res_vld_i   (sum_vld),
        .loop_en_o   (loop_en_o),
        .pass_take_o (pass_take),
        .stamp_o     (res_coarse_o),
        .ovf_cnt_o   (ovf_cnt_o)
    );

    tdc_phase_encoder #(
        .NPH (NPH)
    ) u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld_i  (pass_take),
        .smp_i      (pass_smp_i),
        .fine_vld_o (fine_vld),
        .fine_o     (fine_word)
    );

    tdc_pass_accum #(
        .FW (FW),
        .N  (N)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .fine_vld_i (fine_vld),
        .fine_i     (fine_word),
        .res_vld_o  (sum_vld),
        .res_sum_o  (sum_val)
    );

    assign res_vld_o  = sum_vld;
    assign res_fine_o = sum_val;

endmodule

// File: rtl/tdc_mp_checker.sv
module tdc_mp_checker #(
    parameter int NPH      = 4,
    parameter int N        = 8,
    parameter int OVF_W    = 8,
    parameter int COARSE_W = 16,
    parameter int SW       = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic                hit_i,
    input logic                pass_vld_i,
    input logic                loop_en_o,
    input logic                res_vld_o,
    input logic [COARSE_W-1:0] res_coarse_o,
    input logic [SW-1:0]       res_fine_o,
    input logic [OVF_W-1:0]    ovf_cnt_o
);
    localparam int PW = $clog2(N + 1);

    logic [PW-1:0] seen_q;

    // passes observed while the gate is open
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (!loop_en_o) begin
            seen_q <= '0;
        end else if (pass_vld_i) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    a_r2_gate_opens_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(loop_en_o) |-> $past(hit_i));

    a_r3_closes_after_n: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(loop_en_o) |-> ($past(pass_vld_i) && ($past(seen_q) == PW'(N - 1))));

    a_r3_no_result_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> !loop_en_o);

    a_r5_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o);

    a_r5_sum_bound: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> (32'(res_fine_o) <= NPH * N));

    a_r9_stamp_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_o && $past(loop_en_o)) |-> $stable(res_coarse_o));

    a_r8_drop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && loop_en_o && (ovf_cnt_o != {OVF_W{1'b1}}))
        |=> (ovf_cnt_o == $past(ovf_cnt_o) + 1'b1));

    a_r8_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_cnt_o == {OVF_W{1'b1}}) |=> (ovf_cnt_o == {OVF_W{1'b1}}));

endmodule

bind tdc_multiphase_refine tdc_mp_checker #(
    .NPH      (NPH),
    .N        (N),
    .OVF_W    (OVF_W),
    .COARSE_W (COARSE_W),
    .SW       (SW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hit_i),
    .pass_vld_i   (pass_vld_i),
    .loop_en_o    (loop_en_o),
    .res_vld_o    (res_vld_o),
    .res_coarse_o (res_coarse_o),
    .res_fine_o   (res_fine_o),
    .ovf_cnt_o    (ovf_cnt_o)
);

// File: tb/tdc_multiphase_refine_test.sv
module tdc_multiphase_refine_test;
    localparam int NPH      = 4;
    localparam int N        = 8;
    localparam int DEAD_CYC = 6;
    localparam int OVF_W    = 8;
    localparam int COARSE_W = 16;
    localparam int SW       = $clog2(NPH + 1) + $clog2(N);
    localparam int OVF_MAX  = (1 << OVF_W) - 1;

    typedef logic [NPH-1:0] pat_t;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                hit_i = 1'b0;
    logic                pass_vld_i = 1'b0;
    logic [NPH-1:0]      pass_smp_i = '0;
    logic                loop_en_o;
    logic                res_vld_o;
    logic [COARSE_W-1:0] res_coarse_o;
    logic [SW-1:0]       res_fine_o;
    logic [OVF_W-1:0]    ovf_cnt_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_ovf = 0;
    int exp_coarse = 0;

    tdc_multiphase_refine #(
        .NPH(NPH), .N(N), .DEAD_CYC(DEAD_CYC), .OVF_W(OVF_W), .COARSE_W(COARSE_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_i), .pass_vld_i(pass_vld_i),
        .pass_smp_i(pass_smp_i), .loop_en_o(loop_en_o), .res_vld_o(res_vld_o),
        .res_coarse_o(res_coarse_o), .res_fine_o(res_fine_o), .ovf_cnt_o(ovf_cnt_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int popc(input pat_t p);
        int c = 0;
        for (int k = 0; k < NPH; k++) if (p[k]) c++;
        return c;
    endfunction

    task automatic bump_ovf();
        if (exp_ovf < OVF_MAX) exp_ovf++;
    endtask

    task automatic start_hit(input string tag);
        hit_i = 1'b1;
        exp_coarse = cyc % (1 << COARSE_W);
        @(negedge clk);
        hit_i = 1'b0;
        chk({"R2 gate open ", tag}, int'(loop_en_o), 1);
    endtask

    // feeds N passes, ends at the negedge where the result is visible
    task automatic feed(input pat_t p[N], input bit extra, input bit midhit, input string tag);
        int exp_sum = 0;
        for (int i = 0; i < N; i++) begin
            pass_vld_i = 1'b1;
            pass_smp_i = p[i];
            exp_sum += popc(p[i]);
            if (midhit && i == 2) hit_i = 1'b1;
            @(negedge clk);
            if (midhit && i == 2) begin
                hit_i = 1'b0;
                bump_ovf();
                chk({"R8 hit while open ", tag}, int'(ovf_cnt_o), exp_ovf);
            end
        end
        pass_vld_i = extra;
        pass_smp_i = '1;
        chk({"R3 gate closed ", tag}, int'(loop_en_o), 0);
        chk({"R5 no early result ", tag}, int'(res_vld_o), 0);
        @(negedge clk);
        pass_vld_i = 1'b0;
        pass_smp_i = '0;
        chk({"R5 still no result ", tag}, int'(res_vld_o), 0);
        @(negedge clk);
        chk({"R5 result strobe ", tag}, int'(res_vld_o), 1);
        chk({"R4 R5 fine sum ", tag}, int'(res_fine_o), exp_sum);
        chk({"R9 coarse stamp ", tag}, int'(res_coarse_o), exp_coarse);
    endtask

    task automatic settle();
        repeat (DEAD_CYC + 3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 loop_en at reset", int'(loop_en_o), 0);
        chk("R1 res_vld at reset", int'(res_vld_o), 0);
        chk("R1 ovf at reset", int'(ovf_cnt_o), 0);
    endtask

    task automatic t_uniform();
        pat_t p[N];
        foreach (p[i]) p[i] = 4'b0011;
        start_hit("uniform");
        feed(p, 1'b0, 1'b0, "uniform");
        @(negedge clk);
        chk("R5 strobe one cycle", int'(res_vld_o), 0);
        settle();
    endtask

    task automatic t_bubble();
        pat_t p[N];
        p = '{4'b0001, 4'b0101, 4'b1000, 4'b1111, 4'b0000, 4'b1011, 4'b0110, 4'b0111};
        start_hit("bubble");
        feed(p, 1'b0, 1'b0, "bubble R4");
        settle();
    endtask

    task automatic t_ignored_passes();
        pat_t p[N];
        foreach (p[i]) p[i] = 4'b0000;
        pass_vld_i = 1'b1;
        pass_smp_i = '1;
        repeat (3) @(negedge clk);
        pass_vld_i = 1'b0;
        chk("R6 idle passes keep gate shut", int'(loop_en_o), 0);
        start_hit("ignored");
        feed(p, 1'b1, 1'b0, "R6 ignored");
        settle();
    endtask

    task automatic t_full_scale();
        pat_t p[N];
        foreach (p[i]) p[i] = '1;
        start_hit("full");
        feed(p, 1'b0, 1'b0, "R5 full scale");
        settle();
    endtask

    task automatic t_dead_edge();
        pat_t p[N];
        foreach (p[i]) p[i] = 4'b0111;
        start_hit("dead");
        feed(p, 1'b0, 1'b0, "dead");
        repeat (DEAD_CYC) @(negedge clk);
        hit_i = 1'b1;
        @(negedge clk);
        hit_i = 1'b0;
        bump_ovf();
        chk("R7 last dead edge drops hit", int'(loop_en_o), 0);
        chk("R8 dead hit counted", int'(ovf_cnt_o), exp_ovf);
        start_hit("R7 first live edge");
        foreach (p[i]) p[i] = 4'b0001;
        feed(p, 1'b0, 1'b0, "after dead");
        settle();
    endtask

    task automatic t_mid_hit();
        pat_t p[N];
        p = '{4'b0011, 4'b0111, 4'b0011, 4'b0001, 4'b0011, 4'b0111, 4'b0011, 4'b0001};
        start_hit("mid");
        feed(p, 1'b0, 1'b1, "mid hit");
        settle();
    endtask

    task automatic t_saturate();
        pat_t p[N];
        foreach (p[i]) p[i] = 4'b1110;
        start_hit("sat");
        hit_i = 1'b1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            bump_ovf();
        end
        hit_i = 1'b0;
        chk("R8 ovf saturates", int'(ovf_cnt_o), OVF_MAX);
        chk("R8 gate stayed open", int'(loop_en_o), 1);
        feed(p, 1'b0, 1'b0, "sat");
        settle();
        chk("R8 ovf held at max", int'(ovf_cnt_o), OVF_MAX);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_uniform();
        t_bubble();
        t_ignored_passes();
        t_full_scale();
        t_dead_edge();
        t_mid_hit();
        t_saturate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule